// File: doc/BRIEF.md
# TDM Serial Frame Timing Generator

This block produces the bit-level timing of a time-division-multiplexed synchronous serial link. The link carries one transmit direction and one receive direction. The serial bit clock clocks the block directly. A bit counter steps through each word, and a slot counter steps through a fixed frame of sixteen word slots. From these two counts the block derives a frame sync output, a flag that marks the slots that carry data, and word-start and word-end strobes. A separate shift register uses these strobes, together with the slot index, to move data in and out.

The frame sync is either one bit clock wide or one whole word wide. It is active high or active low. The receive side uses the same width and polarity rules to recognise an incoming frame sync. When external sync is selected, the active edge of that signal realigns the counters to the first bit of the first slot. The configuration is latched when the block is enabled and held until it is disabled, so a change made while the block runs has no effect.

Top module: `tdm_frame_timer`

## Requirements
- R1: While the block is idle (reset, or `en` low on the previous clock edge), `slot_valid`, `word_start` and `word_end` are 0 and `slot_idx` is 0. `fs_out` sits at its inactive level, which equals the live `cfg_sync_fall` input. The first clock edge with `en` high starts the frame, and the next cycle is bit 0 of slot index 0.
- R2: While running, the bit position counts 0 to `cfg_wlen_m1` (word length minus one) and then wraps to 0. `word_end` marks the last bit of a word and `word_start` marks bit 0, both only in valid slots.
- R3: `slot_idx` advances by one after the last bit of each word. It wraps from 15 to 0 in a fixed frame of 16 slots. Index 0 is the first slot.
- R4: `slot_valid` is 1 exactly when `slot_idx` is less than N. N is `cfg_slots`, except that a value of 0 selects N = 16.
- R5: `word_start` and `word_end` are never asserted in a slot whose `slot_valid` is 0.
- R6: When `cfg_wide_sync` is 0, frame sync is asserted only during bit 0 of slot index 0.
- R7: When `cfg_wide_sync` is 1, frame sync is asserted for every bit of slot index 0.
- R8: `fs_out` is high when frame sync is asserted and `cfg_sync_fall` is 0 (rising edge active). It is low when frame sync is asserted and `cfg_sync_fall` is 1 (falling edge active). The polarity setting is the same one that the receive side uses.
- R9: All configuration inputs are latched on the edge that starts the frame. Changes made while running have no effect until the block is disabled and enabled again.
- R10: When the latched `cfg_ext_sync` is 1, an active edge on `rx_fs` makes the next cycle bit 0 of slot index 0, even in the middle of a frame. The active edge is a 0-to-1 change for polarity 0 and a 1-to-0 change for polarity 1. When `cfg_ext_sync` is 0, `rx_fs` is ignored.
- R11: Lowering `en` returns the block to the idle outputs of R1 on the next cycle, at any point in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable covering both directions |
| cfg_slots | input | 4 | Number of valid slots, 0 selects 16 |
| cfg_wide_sync | input | 1 | 1: sync lasts one word; 0: sync lasts one bit |
| cfg_sync_fall | input | 1 | 0: rising edge active; 1: falling edge active |
| cfg_ext_sync | input | 1 | Realign counters on active edges of rx_fs |
| cfg_wlen_m1 | input | 5 | Word length minus one |
| rx_fs | input | 1 | Incoming frame sync, synchronous to clk |
| fs_out | output | 1 | Generated frame sync |
| slot_idx | output | 4 | Current slot index, 0 is the first slot |
| slot_valid | output | 1 | Current slot carries data |
| word_start | output | 1 | Bit 0 of a valid slot |
| word_end | output | 1 | Last bit of a valid slot |

## Verification
The embedded assertions assume that `rx_fs` is already synchronous to the bit clock and that every input is stable around the clock edge. The bench meets both by driving all inputs on the falling edge. The assertions do not require the configuration to stay still while the block runs. The bench changes it deliberately during one run to show that the latched copy is unaffected. It also toggles `rx_fs` while external sync is off, and sends both early and on-time sync edges in both polarities.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int SLOT_W  = 4;
    localparam int WLEN_W  = 5;
    localparam int NSLOTS  = 1 << SLOT_W;

    typedef struct packed {
        logic [SLOT_W-1:0] slots;
        logic              wide;
        logic              fall;
        logic              ext;
        logic [WLEN_W-1:0] wlen_m1;
    } tdm_cfg_t;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [WLEN_W-1:0] bitp;
    } tdm_pos_t;

    // Field value 0 encodes the full frame.
    function automatic logic [SLOT_W:0] slot_limit(input logic [SLOT_W-1:0] f);
        return (f == '0) ? (SLOT_W+1)'(NSLOTS) : {1'b0, f};
    endfunction

    function automatic logic active_edge(input logic fall, input logic prev, input logic cur);
        return fall ? (prev & ~cur) : (~prev & cur);
    endfunction

endpackage

// File: rtl/tdm_cfg_hold.sv
module tdm_cfg_hold
    import tdm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  tdm_cfg_t cfg_in,
    output logic     active,
    output tdm_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cfg_q  <= '0;
        end else if (!en) begin
            active <= 1'b0;
        end else if (!active) begin
            active <= 1'b1;
            cfg_q  <= cfg_in;
        end
    end

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (active && en) |=> $stable(cfg_q));

    p_stop_r11: assert property (@(posedge clk) disable iff (rst)
        !en |=> !active);

endmodule

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge
    import tdm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx,
    input  logic fall,
    output logic hit
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= rx;
    end

    always_comb hit = active_edge(fall, prev_q, rx);

endmodule

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter
    import tdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              resync,
    input  logic [WLEN_W-1:0] wlen_m1,
    output tdm_pos_t          pos
);

    logic word_last;
    always_comb word_last = (pos.bitp == wlen_m1);

    always_ff @(posedge clk) begin
        if (rst || !run || resync) begin
            pos <= '0;
        end else if (word_last) begin
            pos.bitp <= '0;
            pos.slot <= pos.slot + 1'b1;
        end else begin
            pos.bitp <= pos.bitp + 1'b1;
        end
    end

    p_bit_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run |-> (pos.bitp <= wlen_m1));

    p_slot_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !resync && word_last && (pos.slot == SLOT_W'(NSLOTS-1))) |=> (pos.slot == '0));

    p_realign_r10: assert property (@(posedge clk) disable iff (rst)
        (run && resync) |=> (pos == '0));

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [SLOT_W-1:0] cfg_slots,
    input  logic              cfg_wide_sync,
    input  logic              cfg_sync_fall,
    input  logic              cfg_ext_sync,
    input  logic [WLEN_W-1:0] cfg_wlen_m1,
    input  logic              rx_fs,
    output logic              fs_out,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              slot_valid,
    output logic              word_start,
    output logic              word_end
);

    tdm_cfg_t cfg_live, cfg_q;
    tdm_pos_t pos;
    logic     active, rx_hit, resync, sync_on;

    always_comb begin
        cfg_live.slots   = cfg_slots;
        cfg_live.wide    = cfg_wide_sync;
        cfg_live.fall    = cfg_sync_fall;
        cfg_live.ext     = cfg_ext_sync;
        cfg_live.wlen_m1 = cfg_wlen_m1;
    end

    tdm_cfg_hold u_hold (
        .clk(clk), .rst(rst), .en(en), .cfg_in(cfg_live),
        .active(active), .cfg_q(cfg_q)
    );

    tdm_rx_edge u_edge (
        .clk(clk), .rst(rst), .rx(rx_fs), .fall(cfg_q.fall), .hit(rx_hit)
    );

    always_comb resync = active && cfg_q.ext && rx_hit;

    tdm_pos_counter u_cnt (
        .clk(clk), .rst(rst), .run(active && en), .resync(resync),
        .wlen_m1(cfg_q.wlen_m1), .pos(pos)
    );

    always_comb begin
        slot_idx   = active ? pos.slot : '0;
        slot_valid = active && ({1'b0, pos.slot} < slot_limit(cfg_q.slots));
        word_start = slot_valid && (pos.bitp == '0);
        word_end   = slot_valid && (pos.bitp == cfg_q.wlen_m1);
        sync_on    = active && (pos.slot == '0) && (cfg_q.wide || pos.bitp == '0);
        fs_out     = active ? (sync_on ^ cfg_q.fall) : cfg_sync_fall;
    end

    p_strobe_valid_r5: assert property (@(posedge clk) disable iff (rst)
        (word_start || word_end) |-> slot_valid);

    p_idle_level_r1: assert property (@(posedge clk) disable iff (rst)
        !active |-> (fs_out == cfg_sync_fall && !slot_valid && slot_idx == '0));

    p_valid_count_r4: assert property (@(posedge clk) disable iff (rst)
        slot_valid |-> ({1'b0, slot_idx} < slot_limit(cfg_q.slots)));

    p_narrow_sync_r6: assert property (@(posedge clk) disable iff (rst)
        (active && !cfg_q.wide && fs_out != cfg_q.fall) |-> (pos.bitp == '0 && slot_idx == '0));

    p_wide_sync_r7: assert property (@(posedge clk) disable iff (rst)
        (active && cfg_q.wide && slot_idx == '0) |-> (fs_out != cfg_q.fall));

endmodule

// File: tb/tdm_frame_timer_tb.sv
module tdm_frame_timer_tb_top;

    localparam int CLK_P  = 10;
    localparam int MAX_CY = 20000;

    logic       clk = 1'b0;
    logic       rst, en, wide, fall, ext, rx;
    logic [3:0] slots;
    logic [4:0] wlm1;
    logic       fs_out, slot_valid, word_start, word_end;
    logic [3:0] slot_idx;

    int    errors = 0;
    int    checks = 0;
    bit    chk_on = 0;
    bit    done   = 0;
    string tag    = "R1";

    always #(CLK_P/2) clk = ~clk;

    tdm_frame_timer dut_i (
        .clk(clk), .rst(rst), .en(en), .cfg_slots(slots), .cfg_wide_sync(wide),
        .cfg_sync_fall(fall), .cfg_ext_sync(ext), .cfg_wlen_m1(wlm1), .rx_fs(rx),
        .fs_out(fs_out), .slot_idx(slot_idx), .slot_valid(slot_valid),
        .word_start(word_start), .word_end(word_end)
    );

    // Behavioural reference: running flag, bit and slot positions, latched settings.
    int m_act, m_bit, m_slot, m_prev;
    int h_slots, h_wide, h_fall, h_ext, h_wl;

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_bit = 0; m_slot = 0; m_prev = 0;
        end else begin
            int hit;
            hit = m_act && h_ext && (h_fall ? (m_prev == 1 && rx == 0) : (m_prev == 0 && rx == 1));
            if (!en) begin
                m_act = 0; m_bit = 0; m_slot = 0;
            end else if (!m_act) begin
                m_act = 1; m_bit = 0; m_slot = 0;
                h_slots = slots; h_wide = wide; h_fall = fall; h_ext = ext; h_wl = wlm1;
            end else if (hit) begin
                m_bit = 0; m_slot = 0;
            end else if (m_bit == h_wl) begin
                m_bit = 0; m_slot = (m_slot + 1) % 16;
            end else begin
                m_bit = m_bit + 1;
            end
            m_prev = rx;
        end
    end

    task automatic check(string what, string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s, phase %s] got %0d expected %0d", what, req, tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #(CLK_P/4);
        if (chk_on && !done) begin
            int n, v, ws, we, sy, fs, idx;
            n   = (h_slots == 0) ? 16 : h_slots;
            v   = m_act && (m_slot < n);
            ws  = v && (m_bit == 0);
            we  = v && (m_bit == h_wl);
            sy  = m_act && (m_slot == 0) && (h_wide || m_bit == 0);
            fs  = m_act ? (sy ^ h_fall) : fall;
            idx = m_act ? m_slot : 0;
            check("fs_out",     "R8", fs_out,     fs);
            check("slot_idx",   "R3", slot_idx,   idx);
            check("slot_valid", "R4", slot_valid, v);
            check("word_start", "R5", word_start, ws);
            check("word_end",   "R2", word_end,   we);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (MAX_CY) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog [all] got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        h_slots = 0; h_wide = 0; h_fall = 0; h_ext = 0; h_wl = 0;
        rst = 1; en = 0; slots = 4'd3; wide = 0; fall = 0; ext = 0; wlm1 = 5'd7; rx = 0;
        @(posedge clk);
        cyc(1);
        chk_on = 1;
        tag = "R1 reset";
        cyc(2);
        rst = 0;
        cyc(3);

        // R2 R3 R4 R5 R6: narrow rising sync, 3 valid slots, 8-bit words; rx toggles but ext off (R10 ignore).
        tag = "R6 narrow";
        en = 1;
        for (int i = 0; i < 270; i++) begin
            if (i % 5 == 0) rx = ~rx;
            cyc(1);
        end

        // R11: stop mid-frame, then idle with falling polarity level.
        tag = "R11 stop";
        en = 0;
        cyc(2);
        fall = 1; wide = 1; slots = 4'd0; wlm1 = 5'd3; rx = 1;
        cyc(3);

        // R7 R8: wide falling sync, all 16 slots valid, 4-bit words.
        tag = "R7 wide";
        en = 1;
        cyc(140);

        // R9: settings changed while running must be ignored.
        tag = "R9 frozen";
        slots = 4'd1; wide = 0; fall = 0; wlm1 = 5'd15; ext = 1;
        for (int i = 0; i < 40; i++) begin
            rx = ~rx;
            cyc(1);
        end
        en = 0;
        cyc(2);

        // R10: external rising-edge sync, early and on-time pulses.
        tag = "R10 ext rise";
        slots = 4'd5; wide = 0; fall = 0; ext = 1; wlm1 = 5'd7; rx = 0;
        cyc(1);
        en = 1;
        cyc(12);
        rx = 1; cyc(1); rx = 0;
        cyc(30);
        rx = 1; cyc(3); rx = 0;
        cyc(140);

        // R10: external falling-edge sync, wide, word length of one bit.
        tag = "R10 ext fall";
        en = 0;
        cyc(1);
        fall = 1; wide = 1; rx = 1; wlm1 = 5'd0; slots = 4'd2;
        cyc(2);
        en = 1;
        cyc(9);
        rx = 0; cyc(1); rx = 1;
        cyc(20);
        rx = 0; cyc(2); rx = 1;
        cyc(25);

        // R11 and R1: immediate stop then restart.
        tag = "R11 restart";
        en = 0;
        cyc(1);
        ext = 0; wlm1 = 5'd2; slots = 4'd15; wide = 0; fall = 0;
        en = 1;
        cyc(60);
        en = 0;
        cyc(4);

        done = 1;
        summary();
        $finish;
    end

endmodule